// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block turns the classic two-register indirect scheme for PCI configuration access into requests on a downstream configuration interface. The CPU sees two ports. The first is a 32-bit address port, selected with `cpuSel` = 0. The second is a four-byte data port, selected with `cpuSel` = 1. Every CPU access carries a byte offset within its port and a length of 1, 2 or 4 bytes.

Software first loads the address port with an enable flag and a bus/device/function/register tuple. It then reads or writes the data port. The bridge combines the stored address with the data-port byte offset and decodes the result into routing fields. It then checks the downstream status inputs for that target. A request goes out only when access is enabled and the target is fit to answer. Otherwise a read returns all-ones and a write is discarded.

Every CPU access is answered one cycle after it is presented. The downstream side is combinational and works within the cycle of the access. The target returns its status and read data in that same cycle.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the stored address is 0. An address-port read returns 0, and a data-port read returns 0xFFFFFFFF with no downstream request.
- R2: An address-port write updates the stored address only when its offset is 0 and its length is 4. Any other offset or length leaves the stored value unchanged.
- R3: An address-port read returns the whole 32-bit stored value for any offset or length.
- R4: While bit 31 of the stored address is 0, data-port reads return 0xFFFFFFFF and data-port writes raise no downstream request.
- R5: The forwarded address is the stored address ORed with the two low bits of the data-port offset. It is decoded as bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register = bits 7:0, which keeps the register offset inside a 256-byte space. Bits 30:24 are ignored.
- R6: When `cfgPresent` is 0, a data-port read returns 0xFFFFFFFF and a data-port write raises no request.
- R7: When `cfgEnabled` is 0, a data-port read returns 0xFFFFFFFF and a data-port write raises no request.
- R8: When the forwarded function is non-zero and `cfgFunc0Present` is 0, a data-port read returns 0xFFFFFFFF and a write raises no request. Function 0 itself is not affected by `cfgFunc0Present`.
- R9: The length sent downstream is the smaller of the requested length and 256 minus the register offset.
- R10: Read data from a target that answers is returned right-aligned: byte k of `cfgRdata` goes to byte k of `cpuRdata` for k below the clipped length, and the bytes above it read as 0.
- R11: A request presented in one cycle is acknowledged by `cpuAck` in the next cycle, and `cpuAck` stays low in the cycle after a cycle with no request. The downstream request, when one is raised, is valid in the same cycle as the CPU request and carries `cpuWrite` and `cpuWdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access presented this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuSel | input | 1 | 0 = address port, 1 = data port |
| cpuOffset | input | 2 | Byte offset within the selected port |
| cpuLen | input | 3 | Access length in bytes (1, 2 or 4) |
| cpuWdata | input | 32 | CPU write data, right-aligned |
| cpuAck | output | 1 | Access completed, one cycle after cpuReq |
| cpuRdata | output | 32 | Read data, valid with cpuAck |
| cfgReqValid | output | 1 | Downstream configuration request |
| cfgWrite | output | 1 | Downstream request is a write |
| cfgBus | output | 8 | Decoded bus number |
| cfgDev | output | 5 | Decoded device number |
| cfgFunc | output | 3 | Decoded function number |
| cfgReg | output | 8 | Decoded register offset |
| cfgLen | output | 3 | Clipped transfer length in bytes |
| cfgWdata | output | 32 | Downstream write data |
| cfgRdata | input | 32 | Target read data, right-aligned |
| cfgPresent | input | 1 | A target exists at the decoded bus/device/function |
| cfgEnabled | input | 1 | The target is enabled |
| cfgFunc0Present | input | 1 | Function 0 of the decoded device exists |

## Verification
The hardest case to reach from the ports is length clipping. It only happens when the stored register offset sits within three bytes of the end of the 256-byte space. The data-port offset is ORed into the address, so the clipped length depends on both inputs together. The stimulus loads the address port with register 0xFC and then accesses the data port at offsets 2 and 3 with length 4. This yields clipped lengths of 2 and 1 and the matching zero-filled read data. The orphaned-function case is reached in a similar way: the bench drives a non-zero function number with its function-0 status low, and then repeats the same access at function 0.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BYTES     = DATA_W / 8;
  localparam int unsigned OFS_W     = $clog2(BYTES);
  localparam int unsigned LEN_W     = $clog2(BYTES) + 1;
  localparam int unsigned SPACE     = 256;
  localparam int unsigned REG_W     = $clog2(SPACE);
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned BUS_LSB   = 16;
  localparam int unsigned DEV_LSB   = 11;
  localparam int unsigned FUNC_LSB  = 8;

  typedef enum logic [1:0] {
    RD_ADDR = 2'd0,
    RD_DEV  = 2'd1,
    RD_ONES = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   addrWe;
    logic   fwdReq;
    logic   ackNext;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
(
  input  logic             cpuReq,
  input  logic             cpuWrite,
  input  logic             cpuSel,
  input  logic [OFS_W-1:0] cpuOffset,
  input  logic [LEN_W-1:0] cpuLen,
  input  logic             accessEn,
  input  logic [2:0]       fwdFunc,
  input  logic             cfgPresent,
  input  logic             cfgEnabled,
  input  logic             cfgFunc0Present,
  output strobes_t         st
);
  logic fullDword;
  logic targetOk;
  logic dataHit;

  assign fullDword = (cpuOffset == '0) && (cpuLen == LEN_W'(BYTES));
  assign targetOk  = cfgPresent && cfgEnabled &&
                     ((fwdFunc == 3'd0) || cfgFunc0Present);
  assign dataHit   = cpuReq && cpuSel && accessEn && targetOk;

  always_comb begin
    st.addrWe  = cpuReq && cpuWrite && !cpuSel && fullDword;
    st.fwdReq  = dataHit;
    st.ackNext = cpuReq;
    if (!cpuSel)      st.rdSel = RD_ADDR;
    else if (dataHit) st.rdSel = RD_DEV;
    else              st.rdSel = RD_ONES;
  end
endmodule

// File: rtl/cfg_port_dpath.sv
module cfg_port_dpath
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [OFS_W-1:0]  cpuOffset,
  input  logic [LEN_W-1:0]  cpuLen,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] cfgRdata,
  output logic [DATA_W-1:0] addrQ,
  output logic              accessEn,
  output logic [7:0]        fwdBus,
  output logic [4:0]        fwdDev,
  output logic [2:0]        fwdFunc,
  output logic [REG_W-1:0]  fwdReg,
  output logic [LEN_W-1:0]  clipLen,
  output logic              cpuAck,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int unsigned REM_W = REG_W + 1;

  logic [DATA_W-1:0] fwdAddr;
  logic [REM_W-1:0]  remain;
  logic [DATA_W-1:0] devMasked;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN)          addrQ <= '0;
    else if (st.addrWe) addrQ <= cpuWdata;
  end

  assign accessEn = addrQ[EN_BIT];
  assign fwdAddr  = addrQ | DATA_W'(cpuOffset);
  assign fwdBus   = fwdAddr[BUS_LSB +: 8];
  assign fwdDev   = fwdAddr[DEV_LSB +: 5];
  assign fwdFunc  = fwdAddr[FUNC_LSB +: 3];
  assign fwdReg   = fwdAddr[REG_W-1:0];

  assign remain  = REM_W'(SPACE) - REM_W'(fwdReg);
  assign clipLen = (REM_W'(cpuLen) < remain) ? cpuLen : LEN_W'(remain);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign devMasked[8*b +: 8] = (LEN_W'(b) < clipLen) ? cfgRdata[8*b +: 8] : 8'h00;
  end

  always_comb begin
    unique case (st.rdSel)
      RD_ADDR: rdNext = addrQ;
      RD_DEV:  rdNext = devMasked;
      default: rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuAck   <= 1'b0;
      cpuRdata <= '0;
    end else begin
      cpuAck <= st.ackNext;
      if (st.ackNext) cpuRdata <= rdNext;
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic        cpuSel,
  input  logic [1:0]  cpuOffset,
  input  logic [2:0]  cpuLen,
  input  logic [31:0] cpuWdata,
  output logic        cpuAck,
  output logic [31:0] cpuRdata,
  output logic        cfgReqValid,
  output logic        cfgWrite,
  output logic [7:0]  cfgBus,
  output logic [4:0]  cfgDev,
  output logic [2:0]  cfgFunc,
  output logic [7:0]  cfgReg,
  output logic [2:0]  cfgLen,
  output logic [31:0] cfgWdata,
  input  logic [31:0] cfgRdata,
  input  logic        cfgPresent,
  input  logic        cfgEnabled,
  input  logic        cfgFunc0Present
);
  strobes_t    st;
  logic [31:0] addrQ;
  logic        accessEn;

  cfg_port_ctrl i_ctrl (
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuSel(cpuSel),
    .cpuOffset(cpuOffset), .cpuLen(cpuLen), .accessEn(accessEn),
    .fwdFunc(cfgFunc), .cfgPresent(cfgPresent), .cfgEnabled(cfgEnabled),
    .cfgFunc0Present(cfgFunc0Present), .st(st)
  );

  cfg_port_dpath i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .cpuOffset(cpuOffset), .cpuLen(cpuLen),
    .cpuWdata(cpuWdata), .cfgRdata(cfgRdata), .addrQ(addrQ), .accessEn(accessEn),
    .fwdBus(cfgBus), .fwdDev(cfgDev), .fwdFunc(cfgFunc), .fwdReg(cfgReg),
    .clipLen(cfgLen), .cpuAck(cpuAck), .cpuRdata(cpuRdata)
  );

  assign cfgReqValid = st.fwdReq;
  assign cfgWrite    = cpuWrite;
  assign cfgWdata    = cpuWdata;
endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWrite,
  input logic        cpuSel,
  input logic [1:0]  cpuOffset,
  input logic [2:0]  cpuLen,
  input logic        cpuAck,
  input logic [31:0] cpuRdata,
  input logic        cfgReqValid,
  input logic [2:0]  cfgFunc,
  input logic [7:0]  cfgReg,
  input logic [2:0]  cfgLen,
  input logic        cfgPresent,
  input logic        cfgEnabled,
  input logic        cfgFunc0Present,
  input logic [31:0] addrQ
);
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |=> cpuAck) else $error("ack missing"); // R11
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |=> !cpuAck) else $error("spurious ack"); // R11
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReq && cpuWrite && !cpuSel && cpuOffset == 2'd0 && cpuLen == 3'd4)
      |=> $stable(addrQ)) else $error("address changed"); // R2
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> addrQ[31] && cpuSel) else $error("request while disabled"); // R4
  AST_REQ_TARGET_OK: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> cfgPresent && cfgEnabled) else $error("request to unfit target"); // R7
  AST_NO_ORPHAN: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> (cfgFunc == 3'd0 || cfgFunc0Present)) else $error("orphan request"); // R8
  AST_LEN_IN_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid |-> (cfgLen != 3'd0 && cfgLen <= cpuLen &&
                     ({1'b0, cfgReg} + {6'd0, cfgLen}) <= 9'd256)) else $error("length overruns"); // R9
  AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuSel && !cpuWrite && !addrQ[31]) |=> cpuRdata == 32'hFFFF_FFFF)
    else $error("disabled read not all-ones"); // R4
endmodule

bind cfg_port_bridge cfg_port_checker i_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuSel(cpuSel),
  .cpuOffset(cpuOffset), .cpuLen(cpuLen), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
  .cfgReqValid(cfgReqValid), .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgLen(cfgLen),
  .cfgPresent(cfgPresent), .cfgEnabled(cfgEnabled),
  .cfgFunc0Present(cfgFunc0Present), .addrQ(addrQ)
);

// File: tb/test_cfg_port_bridge.sv
`timescale 1ns/1ps
module test_cfg_port_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWrite = 1'b0, cpuSel = 1'b0;
  logic [1:0]  cpuOffset = '0;
  logic [2:0]  cpuLen = 3'd4;
  logic [31:0] cpuWdata = '0;
  logic        cpuAck;
  logic [31:0] cpuRdata;
  logic        cfgReqValid, cfgWrite;
  logic [7:0]  cfgBus, cfgReg;
  logic [4:0]  cfgDev;
  logic [2:0]  cfgFunc, cfgLen;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata = 32'h1122_3344;
  logic        cfgPresent = 1'b1, cfgEnabled = 1'b1, cfgFunc0Present = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic        sReq, sWr, sAck;
  logic [7:0]  sBus, sReg;
  logic [4:0]  sDev;
  logic [2:0]  sFunc, sLen;
  logic [31:0] sWdata, sRdata;

  always #2 clk = ~clk;

  cfg_port_bridge i_cfg_port_bridge (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit sel, input logic [1:0] ofs,
                        input logic [2:0] len, input logic [31:0] wd);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuSel = sel; cpuOffset = ofs; cpuLen = len; cpuWdata = wd;
    #1;
    sReq = cfgReqValid; sWr = cfgWrite; sBus = cfgBus; sDev = cfgDev;
    sFunc = cfgFunc; sReg = cfgReg; sLen = cfgLen; sWdata = cfgWdata;
    @(posedge clk); #1;
    sAck = cpuAck; sRdata = cpuRdata;
    cpuReq = 1'b0;
  endtask

  task automatic setAddr(input logic [31:0] a);
    access(1, 0, 2'd0, 3'd4, a);
  endtask

  task automatic t_reset;
    access(0, 0, 2'd0, 3'd4, 0);
    check("R1 addr after reset", sRdata, 32'h0);
    check("R11 ack", {31'd0, sAck}, 32'd1);
    access(0, 1, 2'd0, 3'd4, 0);
    check("R1 data read ones", sRdata, 32'hFFFF_FFFF);
    check("R1 no request", {31'd0, sReq}, 32'd0);
  endtask

  task automatic t_addrPort;
    setAddr(32'h8012_5A40);
    access(0, 0, 2'd2, 3'd1, 0);
    check("R3 full value narrow read", sRdata, 32'h8012_5A40);
    access(1, 0, 2'd0, 3'd2, 32'h0000_FFFF);
    access(1, 0, 2'd1, 3'd4, 32'h1234_5678);
    access(0, 0, 2'd0, 3'd4, 0);
    check("R2 partial writes ignored", sRdata, 32'h8012_5A40);
    @(posedge clk); #1;
    check("R11 idle no ack", {31'd0, cpuAck}, 32'd0);
  endtask

  task automatic t_forward;
    logic [31:0] a;
    a = 32'hFF12_5A40;
    setAddr(a);
    access(0, 1, 2'd3, 3'd1, 0);
    check("R5 request raised", {31'd0, sReq}, 32'd1);
    check("R5 bus", {24'd0, sBus}, {24'd0, a[23:16]});
    check("R5 dev", {27'd0, sDev}, {27'd0, a[15:11]});
    check("R5 func", {29'd0, sFunc}, {29'd0, a[10:8]});
    check("R5 reg ored", {24'd0, sReg}, 32'h43);
    check("R10 one byte", sRdata, 32'h0000_0044);
    access(1, 1, 2'd2, 3'd2, 32'h0000_BEEF);
    check("R11 write request", {30'd0, sReq, sWr}, 32'd3);
    check("R11 wdata", sWdata, 32'h0000_BEEF);
    check("R9 len 2", {29'd0, sLen}, 32'd2);
    access(0, 1, 2'd0, 3'd4, 0);
    check("R10 dword", sRdata, 32'h1122_3344);
  endtask

  task automatic t_disabled;
    setAddr(32'h0012_5A40);
    access(1, 1, 2'd0, 3'd4, 32'h1);
    check("R4 write dropped", {31'd0, sReq}, 32'd0);
    access(0, 1, 2'd0, 3'd4, 0);
    check("R4 read ones", sRdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_target;
    setAddr(32'h8003_0A10);
    cfgPresent = 1'b0;
    access(0, 1, 2'd0, 3'd4, 0);
    check("R6 absent read", sRdata, 32'hFFFF_FFFF);
    access(1, 1, 2'd0, 3'd4, 32'h5);
    check("R6 absent write", {31'd0, sReq}, 32'd0);
    cfgPresent = 1'b1; cfgEnabled = 1'b0;
    access(0, 1, 2'd0, 3'd4, 0);
    check("R7 disabled read", sRdata, 32'hFFFF_FFFF);
    access(1, 1, 2'd0, 3'd4, 32'h5);
    check("R7 disabled write", {31'd0, sReq}, 32'd0);
    cfgEnabled = 1'b1; cfgFunc0Present = 1'b0;
    access(0, 1, 2'd0, 3'd4, 0);
    check("R8 orphan read", sRdata, 32'hFFFF_FFFF);
    access(1, 1, 2'd0, 3'd4, 32'h5);
    check("R8 orphan write", {31'd0, sReq}, 32'd0);
    setAddr(32'h8003_0810);
    access(0, 1, 2'd0, 3'd4, 0);
    check("R8 func0 unaffected", sRdata, 32'h1122_3344);
    cfgFunc0Present = 1'b1;
  endtask

  task automatic t_clip;
    setAddr(32'h8000_00FC);
    access(0, 1, 2'd3, 3'd4, 0);
    check("R9 reg", {24'd0, sReg}, 32'hFF);
    check("R9 clip to 1", {29'd0, sLen}, 32'd1);
    check("R10 clipped data", sRdata, 32'h0000_0044);
    access(0, 1, 2'd2, 3'd4, 0);
    check("R9 clip to 2", {29'd0, sLen}, 32'd2);
    check("R10 two bytes", sRdata, 32'h0000_3344);
    access(0, 1, 2'd0, 3'd4, 0);
    check("R9 no clip", {29'd0, sLen}, 32'd4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_addrPort();
    t_forward();
    t_disabled();
    t_target();
    t_clip();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule